// File: doc/BRIEF.md
# Chained Multiword Funnel Right-Shifter

This block shifts a big integer right by an amount chosen at run time. The integer arrives as a stream of 64-bit limbs, least significant limb first, over a valid/ready handshake. A flag marks the first limb of each number and another flag marks its top limb. On the first limb the block samples a 12-bit shift amount. The upper six bits give a whole-limb offset `k` and the low six bits give a bit offset `b`.

Each incoming limb is rotated right by `b` as a whole. A mask then divides it into a part that stays in this limb and a spill part. The spill bits already sit where the limb below needs them, so ORing them into the previous limb's stay part completes that result limb. This makes the limbs a chained double-word shift. The first `k` limbs are dropped. The top result limb gets zeros from above. Results leave through a registered valid/ready port in input order. Backpressure on that port stalls the input.

Top module: `mw_funnel_shr`

## Requirements
- R1: With `b = in_shamt[5:0]` and `k = in_shamt[11:6]` taken on the first limb, result limb j equals (limb j+k >> b) | (limb j+k+1 << (64-b)) for every j below the top result.
- R2: When b is 0, each result limb equals input limb j+k unchanged, with no bits from the neighbour.
- R3: The top result limb gets zero from above: it equals (top input limb >> b).
- R4: Input limbs with index below k produce no output. A number of N limbs gives exactly N-k result limbs, or none at all when k ≥ N.
- R5: `in_shamt` is used only on a beat that has `in_first` high. Its value on any other beat has no effect on the results.
- R6: `out_last` is high on the top result limb of each number and low on every other result limb.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` stay unchanged, `out_valid` stays high and `in_ready` is low.
- R8: During reset and right after it, `out_valid` is 0 and `in_ready` is 1.
- R9: Result limbs leave in ascending limb order, and numbers leave in the order they arrived.
- R10: Accepting a first limb creates no result in the next cycle. If the output slot was free at that acceptance, `out_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input limb is valid |
| in_ready | output | 1 | Block can take an input limb |
| in_data | input | 64 | Input limb |
| in_first | input | 1 | Limb is the least significant limb of a number |
| in_last | input | 1 | Limb is the most significant limb of a number |
| in_shamt | input | 12 | Shift amount, {limb offset, bit offset}, sampled with in_first |
| out_valid | output | 1 | Result limb is valid |
| out_ready | input | 1 | Consumer takes the result limb |
| out_data | output | 64 | Result limb |
| out_last | output | 1 | Result limb is the top of its number |

## Verification
The top input limb has to produce two results: the merged result for the limb below it, and its own zero-filled top result. The second result goes out in an extra flush cycle. That cycle can fall together with a stall on the output port. The bench provokes this by lowering `out_ready` at random while numbers of one to eight limbs stream in back to back, with every mix of whole-limb and bit offsets. A behavioural queue model, built with plain shifts and no rotation, judges every handshake on the output for data, top-limb flag and order.

// File: rtl/mwshr_pkg.sv
package mwshr_pkg;

    localparam int LIMB_W  = 64;
    localparam int SHAMT_W = 12;
    localparam int BIT_W   = $clog2(LIMB_W);
    localparam int OFF_W   = SHAMT_W - BIT_W;
    localparam int IDX_W   = OFF_W + 1;
    localparam int IDX_MAX = (1 << IDX_W) - 1;

    typedef logic [LIMB_W-1:0] limb_t;
    typedef logic [BIT_W-1:0]  bitoff_t;
    typedef logic [OFF_W-1:0]  limboff_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // what to do with the limb on the input this cycle
    typedef enum logic [1:0] {
        LA_SKIP  = 2'd0,   // below the limb offset: discard
        LA_PARK  = 2'd1,   // first kept limb: store its stay part only
        LA_MERGE = 2'd2    // later kept limb: finish the parked result
    } limb_act_e;

    typedef struct packed {
        limb_t stay;   // bits that remain in this limb after the shift
        limb_t spill;  // bits that belong to the limb below
    } split_t;

    typedef struct packed {
        limboff_t koff;
        bitoff_t  boff;
    } shamt_t;

    function automatic limb_t rot_right(limb_t x, bitoff_t b);
        logic [2*LIMB_W-1:0] dbl;
        dbl = {x, x} >> b;
        return dbl[LIMB_W-1:0];
    endfunction

    function automatic limb_t stay_mask(bitoff_t b);
        return {LIMB_W{1'b1}} >> b;
    endfunction

    function automatic idx_t idx_step(idx_t i);
        return (i == idx_t'(IDX_MAX)) ? i : i + idx_t'(1);
    endfunction

endpackage

// File: rtl/mwshr_split.sv
module mwshr_split
    import mwshr_pkg::*;
(
    input  limb_t   limb,
    input  bitoff_t boff,
    output split_t  parts
);

    limb_t rot;
    limb_t msk;

    always_comb begin
        rot         = rot_right(limb, boff);
        msk         = stay_mask(boff);
        parts.stay  = rot & msk;
        parts.spill = rot & ~msk;
    end

endmodule

// File: rtl/mwshr_seq.sv
module mwshr_seq
    import mwshr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      acc,
    input  logic      first,
    input  logic      last,
    input  shamt_t    shamt,
    output bitoff_t   boff,
    output limb_act_e act,
    output logic      tail
);

    idx_t     idx_q;
    limboff_t koff_q;
    bitoff_t  boff_q;
    idx_t     idx_cur;
    limboff_t koff_cur;
    idx_t     koff_ext;

    always_comb begin
        koff_cur = first ? shamt.koff : koff_q;
        boff     = first ? shamt.boff : boff_q;
        idx_cur  = first ? '0 : idx_q;
        koff_ext = idx_t'(koff_cur);
        if (idx_cur < koff_ext)
            act = LA_SKIP;
        else if (idx_cur == koff_ext)
            act = LA_PARK;
        else
            act = LA_MERGE;
        tail = last && (act != LA_SKIP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            koff_q <= '0;
            boff_q <= '0;
        end else if (acc) begin
            idx_q <= idx_step(idx_cur);
            if (first) begin
                koff_q <= shamt.koff;
                boff_q <= shamt.boff;
            end
        end
    end

endmodule

// File: rtl/mwshr_ostage.sv
module mwshr_ostage
    import mwshr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  limb_t ld_data,
    input  logic  ld_last,
    input  logic  out_ready,
    output logic  out_valid,
    output limb_t out_data,
    output logic  out_last,
    output logic  free
);

    assign free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= ld_data;
            out_last  <= ld_last;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/mw_funnel_shr.sv
module mw_funnel_shr
    import mwshr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [LIMB_W-1:0]  in_data,
    input  logic               in_first,
    input  logic               in_last,
    input  logic [SHAMT_W-1:0] in_shamt,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [LIMB_W-1:0]  out_data,
    output logic               out_last
);

    logic      free;
    logic      acc;
    bitoff_t   boff;
    limb_act_e act;
    logic      tail;
    split_t    parts;
    limb_t     park_q;
    logic      flush_q;
    logic      load;
    limb_t     ld_data;
    logic      ld_last;

    assign in_ready = free && !flush_q;
    assign acc      = in_valid && in_ready;

    mwshr_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .first (in_first),
        .last  (in_last),
        .shamt (shamt_t'(in_shamt)),
        .boff  (boff),
        .act   (act),
        .tail  (tail)
    );

    mwshr_split u_split (
        .limb  (in_data),
        .boff  (boff),
        .parts (parts)
    );

    // result assembly: merge on a kept limb, or drain the top on flush
    always_comb begin
        load    = 1'b0;
        ld_data = park_q;
        ld_last = 1'b0;
        if (flush_q && free) begin
            load    = 1'b1;
            ld_last = 1'b1;
        end else if (acc && act == LA_MERGE) begin
            load    = 1'b1;
            ld_data = park_q | parts.spill;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            park_q  <= '0;
            flush_q <= 1'b0;
        end else begin
            if (acc && act != LA_SKIP)
                park_q <= parts.stay;
            if (acc && tail)
                flush_q <= 1'b1;
            else if (flush_q && free)
                flush_q <= 1'b0;
        end
    end

    mwshr_ostage u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .ld_data   (ld_data),
        .ld_last   (ld_last),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .free      (free)
    );

endmodule

// File: rtl/mwshr_chk.sv
module mwshr_chk
    import mwshr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic [LIMB_W-1:0]  in_data,
    input logic               in_first,
    input logic               in_last,
    input logic [SHAMT_W-1:0] in_shamt,
    input logic               out_valid,
    input logic               out_ready,
    input logic [LIMB_W-1:0]  out_data,
    input logic               out_last
);

    assert_reset_idle_R8: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_stall_input_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    assert_first_silent_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_first && (!out_valid || out_ready)) |=> !out_valid);

    assert_single_pass_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_first && in_last && in_shamt == '0)
        |=> ##1 (out_valid && out_last && out_data == $past(in_data, 2)));

endmodule

bind mw_funnel_shr mwshr_chk u_chk (.*);

// File: tb/sim_mw_funnel_shr.sv
module sim_mw_funnel_shr;
    import mwshr_pkg::*;

    localparam int LIMIT = 150000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [LIMB_W-1:0]  in_data = '0;
    logic               in_first = 1'b0;
    logic               in_last = 1'b0;
    logic [SHAMT_W-1:0] in_shamt = '0;
    logic               out_valid;
    logic               out_ready = 1'b0;
    logic [LIMB_W-1:0]  out_data;
    logic               out_last;

    always #4 clk = ~clk;

    mw_funnel_shr u0 (.*);

    limb_t              b_data[$];
    bit                 b_first[$];
    bit                 b_last[$];
    logic [SHAMT_W-1:0] b_shamt[$];
    limb_t              e_data[$];
    bit                 e_last[$];
    string              e_tag[$];

    int n_cmp = 0;
    int n_bad = 0;
    int exp_total = 0;
    int got_total = 0;

    task automatic chk(bit ok, string tag, limb_t act, limb_t exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic add_number(int n, int s);
        limb_t L[16];
        int k = s / LIMB_W;
        int b = s % LIMB_W;
        for (int i = 0; i < n; i++) begin
            L[i] = {$urandom, $urandom};
            b_data.push_back(L[i]);
            b_first.push_back(i == 0);
            b_last.push_back(i == n - 1);
            b_shamt.push_back(i == 0 ? SHAMT_W'(s) : SHAMT_W'($urandom));
        end
        for (int j = 0; j + k < n; j++) begin
            limb_t lo = L[j+k] >> b;
            limb_t hi = '0;
            string t;
            if (b != 0 && j + k + 1 < n) hi = L[j+k+1] << (LIMB_W - b);
            if (b == 0)              t = "R2 data R9 R5";
            else if (j + k + 1 == n) t = "R3 data R9 R5";
            else                     t = "R1 data R9 R5";
            e_data.push_back(lo | hi);
            e_last.push_back(j + k + 1 == n);
            e_tag.push_back(t);
            exp_total++;
        end
    endtask

    initial begin
        bit    hold_prev = 0;
        limb_t hold_data = '0;
        bit    hold_last = 0;
        bit    first_free = 0;
        int    cyc = 0;

        repeat (3) @(negedge clk);
        chk(!out_valid && in_ready, "R8 reset state", {62'd0, out_valid, in_ready}, 64'd1);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && in_ready, "R8 after reset", {62'd0, out_valid, in_ready}, 64'd1);

        add_number(4, 0);    add_number(4, 1);    add_number(4, 63);
        add_number(4, 64);   add_number(4, 65);   add_number(3, 200);
        add_number(5, 130);  add_number(1, 0);    add_number(1, 7);
        add_number(2, 64);   add_number(6, 191);  add_number(8, 4095);
        add_number(3, 128);  add_number(3, 127);
        for (int r = 0; r < 40; r++) begin
            int n = 1 + ($urandom % 8);
            add_number(n, $urandom % (n * 64 + 70));
        end

        while ((b_data.size() > 0 || e_data.size() > 0) && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            out_ready = ($urandom % 4) != 0;
            if (b_data.size() > 0 && ($urandom % 10) < 7) begin
                in_valid = 1'b1;
                in_data  = b_data[0];
                in_first = b_first[0];
                in_last  = b_last[0];
                in_shamt = b_first[0] ? b_shamt[0] : SHAMT_W'($urandom);
            end else begin
                in_valid = 1'b0;
                in_shamt = SHAMT_W'($urandom);
            end
            #2;
            if (hold_prev)
                chk(out_valid && out_data == hold_data && out_last == hold_last,
                    "R7 held output", out_data, hold_data);
            if (out_valid && !out_ready)
                chk(!in_ready, "R7 input stalled", {63'd0, in_ready}, 64'd0);
            if (first_free)
                chk(!out_valid, "R10 first limb silent", {63'd0, out_valid}, 64'd0);
            if (out_valid && out_ready) begin
                got_total++;
                if (e_data.size() == 0) begin
                    chk(0, "R4 unexpected output", out_data, 64'd0);
                end else begin
                    chk(out_data == e_data[0], e_tag[0], out_data, e_data[0]);
                    chk(out_last == e_last[0], "R6 last flag", {63'd0, out_last}, {63'd0, e_last[0]});
                    void'(e_data.pop_front());
                    void'(e_last.pop_front());
                    void'(e_tag.pop_front());
                end
            end
            first_free = 0;
            if (in_valid && in_ready) begin
                first_free = in_first && (!out_valid || out_ready);
                void'(b_data.pop_front());
                void'(b_first.pop_front());
                void'(b_last.pop_front());
                void'(b_shamt.pop_front());
            end
            hold_prev = out_valid && !out_ready;
            hold_data = out_data;
            hold_last = out_last;
        end

        if (cyc >= LIMIT) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R9 actual=%0d expected<%0d", cyc, LIMIT);
        end

        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            #2;
            if (out_valid) got_total++;
            chk(!out_valid, "R4 no extra output", {63'd0, out_valid}, 64'd0);
        end
        chk(got_total == exp_total, "R4 result count", 64'(got_total), 64'(exp_total));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule